// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each beat of an SDRAM read or write burst. A column command loads a start column together with a length code and an ordering bit. Starting on the next clock, the block presents one column per cycle until the burst ends. A burst ends when it reaches its final beat, when a stop strobe arrives, or when an interrupting command replaces it with a new burst.

Lengths of 1, 2, 4 and 8 beats can be walked either as a wrapping increment inside the aligned block or as an XOR-interleaved order. A full-page burst sweeps the whole 256-column row, wrapping past the top, and runs until it is stopped or replaced. The controller issues every command on a clock edge, and a new command may follow the previous one after a single cycle.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is low and on the first cycle after it, `beat_valid` and `beat_last` are 0.
- R2: When `cmd_start` is high on an edge with no burst running (`beat_valid` low), the next cycle shows `beat_valid`=1 and `col_addr`=`start_col` (beat 0). Each later edge advances one beat.
- R3: Length codes on `blen_code` are 0→1, 1→2, 2→4 and 3→8 beats. When `ilv_mode`=0, beat n keeps the column bits above the low log2(BL) bits equal to the start column. The low bits equal (start low bits + n) mod BL.
- R4: When `ilv_mode`=1 and the length is 1, 2, 4 or 8, beat n shows `start_col` XOR n.
- R5: Code 7 selects full page. Beat n shows (`start_col` + n) mod 256, the ordering bit is ignored, and the burst continues past 256 beats until it is stopped or interrupted.
- R6: `beat_last` is 1 exactly on beat BL-1 of a 1/2/4/8 burst. The cycle after it, `beat_valid` is 0 unless a new burst was loaded. `beat_last` is never 1 in a full-page burst.
- R7: `cmd_start` on an edge while a burst is running has no effect. The running burst continues with its own columns.
- R8: `cmd_stop` on an edge with no new command makes the beat shown in that cycle the final one. `beat_valid` is 0 on the next cycle.
- R9: `cmd_intr` loads a new burst on any edge, whether the block is idle, mid-burst or on a last beat. It takes priority over `cmd_stop`, so that commands one cycle apart each yield their own beat 0.
- R10: Length codes 4, 5 and 6 are treated as a single-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start a burst when idle |
| cmd_intr | input | 1 | Replace any burst with a new one |
| cmd_stop | input | 1 | Terminate the running burst |
| start_col | input | COL_W | Start column of a new burst |
| blen_code | input | 3 | Burst length code |
| ilv_mode | input | 1 | 1 = interleaved order, 0 = sequential |
| col_addr | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The bench builds the block with its defaults: an 8-bit column and the interleaved variant enabled. With these values a full-page sweep of 256 columns, and its wrap back to column 0, fits in a few hundred cycles and can be checked beat by beat. Both orderings of every fixed length are also reachable, including start columns whose upper bits must stay fixed. Directed sequences place stop and interrupt commands on first, middle and last beats and on back-to-back cycles. A seeded random command stream then mixes all of them against the behavioural model.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
   typedef enum logic [2:0] {
      BLEN_1    = 3'd0,
      BLEN_2    = 3'd1,
      BLEN_4    = 3'd2,
      BLEN_8    = 3'd3,
      BLEN_PAGE = 3'd7
   } blen_e;

   localparam int BLEN_W   = 3;
   localparam int MAX_FIXED_LOG = 3;
endpackage

// File: rtl/bcg_lenmask.sv
module bcg_lenmask #(
   parameter int COL_W = 8
) (
   input  logic [bcg_pkg::BLEN_W-1:0] code,
   output logic [COL_W-1:0]           mask,
   output logic                       full
);
   import bcg_pkg::*;

   always_comb begin
      mask = '0;
      full = 1'b0;
      case (code)
         BLEN_2:    mask = COL_W'(1);
         BLEN_4:    mask = COL_W'(3);
         BLEN_8:    mask = COL_W'(7);
         BLEN_PAGE: begin
            mask = '1;
            full = 1'b1;
         end
         default:   mask = '0;
      endcase
   end
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl #(
   parameter int COL_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_start,
   input  logic                       cmd_intr,
   input  logic                       cmd_stop,
   input  logic [COL_W-1:0]           start_col,
   input  logic [bcg_pkg::BLEN_W-1:0] blen_code,
   input  logic                       ilv_mode,
   input  logic [COL_W-1:0]           mask,
   input  logic                       full,
   output logic                       act_q,
   output logic [COL_W-1:0]           cnt_q,
   output logic [COL_W-1:0]           base_q,
   output logic [bcg_pkg::BLEN_W-1:0] code_q,
   output logic                       ilv_q,
   output logic                       last
);
   logic load;

   assign load = cmd_intr | (cmd_start & ~act_q);
   assign last = act_q & ~full & (cnt_q == mask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         cnt_q  <= '0;
         base_q <= '0;
         code_q <= '0;
         ilv_q  <= 1'b0;
      end else if (load) begin
         act_q  <= 1'b1;
         cnt_q  <= '0;
         base_q <= start_col;
         code_q <= blen_code;
         ilv_q  <= ilv_mode;
      end else if (cmd_stop) begin
         act_q  <= 1'b0;
      end else if (act_q) begin
         if (last) act_q <= 1'b0;
         else      cnt_q <= cnt_q + COL_W'(1);
      end
   end
endmodule

// File: rtl/bcg_addr.sv
module bcg_addr #(
   parameter int COL_W    = 8,
   parameter bit INTLV_EN = 1'b1
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] cnt,
   input  logic [COL_W-1:0] mask,
   input  logic             full,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] seq_col;
   logic [COL_W-1:0] sum;

   assign sum     = base + cnt;
   assign seq_col = (base & ~mask) | (sum & mask);

   generate
      if (INTLV_EN) begin : g_ilv
         logic [COL_W-1:0] ilv_col;
         assign ilv_col = base ^ (cnt & mask);
         assign col     = (ilv && !full) ? ilv_col : seq_col;
      end else begin : g_seq_only
         logic unused_ilv;
         assign unused_ilv = ilv;
         assign col        = seq_col;
      end
   endgenerate
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
   parameter int COL_W    = 8,
   parameter bit INTLV_EN = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_start,
   input  logic                       cmd_intr,
   input  logic                       cmd_stop,
   input  logic [COL_W-1:0]           start_col,
   input  logic [bcg_pkg::BLEN_W-1:0] blen_code,
   input  logic                       ilv_mode,
   output logic [COL_W-1:0]           col_addr,
   output logic                       beat_valid,
   output logic                       beat_last
);
   generate
      if (COL_W < bcg_pkg::MAX_FIXED_LOG) begin : g_bad_width
         $error("burst_col_gen: COL_W must cover an 8-beat block");
      end
   endgenerate

   logic                       act_q;
   logic [COL_W-1:0]           cnt_q;
   logic [COL_W-1:0]           base_q;
   logic [bcg_pkg::BLEN_W-1:0] code_q;
   logic                       ilv_q;
   logic [COL_W-1:0]           mask;
   logic                       full;
   logic                       last;

   bcg_lenmask #(.COL_W(COL_W)) u_mask (
      .code (code_q),
      .mask (mask),
      .full (full)
   );

   bcg_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_start (cmd_start),
      .cmd_intr  (cmd_intr),
      .cmd_stop  (cmd_stop),
      .start_col (start_col),
      .blen_code (blen_code),
      .ilv_mode  (ilv_mode),
      .mask      (mask),
      .full      (full),
      .act_q     (act_q),
      .cnt_q     (cnt_q),
      .base_q    (base_q),
      .code_q    (code_q),
      .ilv_q     (ilv_q),
      .last      (last)
   );

   bcg_addr #(.COL_W(COL_W), .INTLV_EN(INTLV_EN)) u_addr (
      .base (base_q),
      .cnt  (cnt_q),
      .mask (mask),
      .full (full),
      .ilv  (ilv_q),
      .col  (col_addr)
   );

   assign beat_valid = act_q;
   assign beat_last  = last;
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
   parameter int COL_W = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cmd_start,
   input logic                       cmd_intr,
   input logic                       cmd_stop,
   input logic [COL_W-1:0]           start_col,
   input logic [bcg_pkg::BLEN_W-1:0] blen_code,
   input logic [COL_W-1:0]           col_addr,
   input logic                       beat_valid,
   input logic                       beat_last
);
   logic page_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         page_q <= 1'b0;
      else if (cmd_intr || (cmd_start && !beat_valid))
         page_q <= (blen_code == bcg_pkg::BLEN_PAGE);
   end

   // R6
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last |-> beat_valid);

   // R6
   last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_last && !cmd_intr |=> !beat_valid);

   // R5
   page_nolast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid && page_q |-> !beat_last);

   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start && !beat_valid |=> beat_valid && col_addr == $past(start_col));

   // R9
   intr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_intr |=> beat_valid && col_addr == $past(start_col));

   // R8
   stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop && !cmd_intr && beat_valid |=> !beat_valid);

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !beat_valid && !cmd_start && !cmd_intr |=> !beat_valid);
endmodule

bind burst_col_gen bcg_chk #(.COL_W(COL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_start  (cmd_start),
   .cmd_intr   (cmd_intr),
   .cmd_stop   (cmd_stop),
   .start_col  (start_col),
   .blen_code  (blen_code),
   .col_addr   (col_addr),
   .beat_valid (beat_valid),
   .beat_last  (beat_last)
);

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cmd_start, cmd_intr, cmd_stop, ilv_mode;
   logic [7:0] start_col, col_addr;
   logic [2:0] blen_code;
   logic       beat_valid, beat_last;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   int m_act, m_n, m_s, m_code, m_ilv;

   always #2.5 clk = ~clk;

   burst_col_gen dut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_intr(cmd_intr),
      .cmd_stop(cmd_stop), .start_col(start_col), .blen_code(blen_code),
      .ilv_mode(ilv_mode), .col_addr(col_addr), .beat_valid(beat_valid),
      .beat_last(beat_last)
   );

   function automatic int blen(int code);
      if (code < 4)  return 1 << code;
      if (code == 7) return 256;
      return 1;
   endfunction

   function automatic int exp_col();
      int bl = blen(m_code);
      if (m_code == 7)     return (m_s + m_n) % 256;
      if (m_ilv != 0)      return m_s ^ m_n;
      return (m_s - (m_s % bl)) + (((m_s % bl) + m_n) % bl);
   endfunction

   function automatic bit exp_last();
      return (m_act != 0) && (m_code != 7) && (m_n == blen(m_code) - 1);
   endfunction

   function automatic string col_tag();
      if (m_code == 7)                 return "R5";
      if (m_code > 3)                  return "R10";
      if (m_ilv != 0)                  return "R4";
      return "R3";
   endfunction

   task automatic check(string note);
      total++;
      if (beat_valid !== (m_act != 0)) begin
         bad++;
         $display("FAIL %s valid: got %0b exp %0b", note, beat_valid, m_act != 0);
      end
      total++;
      if (beat_last !== exp_last()) begin
         bad++;
         $display("FAIL R6/%s last: got %0b exp %0b", note, beat_last, exp_last());
      end
      if (m_act != 0) begin
         total++;
         if (col_addr !== 8'(exp_col())) begin
            bad++;
            $display("FAIL %s/%s col: got %02h exp %02h", col_tag(), note,
                     col_addr, exp_col());
         end
      end
   endtask

   // drive at negedge, advance model for the coming edge, compare at next negedge
   task automatic step(bit s, bit i, bit t, int c, int l, bit v, string note);
      bit was_last;
      cmd_start = s; cmd_intr = i; cmd_stop = t;
      start_col = 8'(c); blen_code = 3'(l); ilv_mode = v;
      was_last = exp_last();
      if (i || (s && m_act == 0)) begin
         m_act = 1; m_n = 0; m_s = c; m_code = l; m_ilv = v;
      end else if (t) begin
         m_act = 0;
      end else if (m_act != 0) begin
         if (was_last) m_act = 0;
         else          m_n = (m_n + 1) % 256;
      end
      @(negedge clk);
      check(note);
   endtask

   task automatic idle(int k, string note);
      for (int j = 0; j < k; j++) step(0, 0, 0, 0, 0, 0, note);
   endtask

   initial begin
      #(5.0 * 150000);
      total++; bad++;
      $display("FAIL watchdog: got hang exp finish");
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
      end
      $finish;
   end

   initial begin
      m_act = 0; m_n = 0; m_s = 0; m_code = 0; m_ilv = 0;
      rst_n = 0; cmd_start = 0; cmd_intr = 0; cmd_stop = 0;
      start_col = 0; blen_code = 0; ilv_mode = 0;
      repeat (3) @(negedge clk);
      check("R1 in reset");
      rst_n = 1;
      step(0, 0, 0, 0, 0, 0, "R1 after reset");

      // R2 R3 sequential lengths
      step(1, 0, 0, 8'h36, 2, 0, "R2 load BL4"); idle(4, "R3 BL4");
      step(1, 0, 0, 8'hFD, 3, 0, "R2 load BL8"); idle(8, "R3 BL8");
      step(1, 0, 0, 8'h21, 1, 0, "R2 load BL2"); idle(3, "R3 BL2");
      step(1, 0, 0, 8'h9C, 0, 0, "R2 load BL1"); idle(2, "R3 BL1");
      // R4 interleaved
      step(1, 0, 0, 8'h45, 3, 1, "R4 BL8"); idle(8, "R4 BL8");
      step(1, 0, 0, 8'h6E, 2, 1, "R4 BL4"); idle(4, "R4 BL4");
      step(1, 0, 0, 8'h13, 1, 1, "R4 BL2"); idle(2, "R4 BL2");
      // R7 start ignored while running
      step(1, 0, 0, 8'h10, 3, 0, "R7 load"); idle(2, "R7 run");
      step(1, 0, 0, 8'h80, 0, 1, "R7 ignored start"); idle(7, "R7 continue");
      // R8 stop mid burst and on beat 0
      step(1, 0, 0, 8'h50, 3, 0, "R8 load"); idle(2, "R8 run");
      step(0, 0, 1, 0, 0, 0, "R8 stop"); idle(2, "R8 after");
      step(1, 0, 0, 8'h58, 2, 1, "R8 load2");
      step(0, 0, 1, 0, 0, 0, "R8 stop beat0"); idle(1, "R8 after2");
      // R9 interrupts
      step(1, 0, 0, 8'h70, 3, 0, "R9 load"); idle(3, "R9 run");
      step(0, 1, 0, 8'hA3, 2, 1, "R9 intr mid"); idle(3, "R9 to last");
      step(0, 1, 0, 8'h04, 1, 0, "R9 intr on last"); idle(1, "R9 run2");
      step(0, 1, 1, 8'hC8, 3, 0, "R9 intr over stop");
      step(0, 1, 0, 8'hC9, 3, 1, "R9 back2back a");
      step(0, 1, 0, 8'hCA, 2, 0, "R9 back2back b");
      step(0, 1, 0, 8'hCB, 7, 0, "R9 back2back c"); idle(9, "R9 tail");
      step(0, 0, 1, 0, 0, 0, "R8 stop page"); idle(1, "R8 idle");
      step(0, 1, 0, 8'h2E, 1, 0, "R9 intr idle"); idle(3, "R9 idle run");
      // R10 reserved codes
      step(1, 0, 0, 8'h33, 5, 0, "R10 code5"); idle(2, "R10 end");
      step(1, 0, 0, 8'h34, 6, 1, "R10 code6"); idle(1, "R10 end2");
      // R5 full page with wrap, ilv ignored
      step(1, 0, 0, 8'hFA, 7, 1, "R5 page load"); idle(262, "R5 page run");
      step(0, 0, 1, 0, 0, 0, "R5 page stop"); idle(2, "R5 page idle");
      // mixed stream
      for (int j = 0; j < 3000; j++) begin
         int r = $urandom_range(0, 99);
         step(r < 12, r >= 12 && r < 18, r >= 18 && r < 23,
              $urandom_range(0, 255), $urandom_range(0, 7),
              1'($urandom_range(0, 1)), "R9 mixed");
      end
      idle(3, "R6 drain");

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
      end
      $finish;
   end
endmodule